// File: doc/BRIEF.md
# I2C Target Address Matcher

This block is the receive front end of an I2C target device. Both bus lines are brought into the system clock domain and cleaned of short glitches. The block then detects START and STOP conditions. After every START, including a repeated START, it shifts in the first byte on the bus, most significant bit first, and decides whether the device is being addressed. Three kinds of address can match: a primary own address in 7-bit or 10-bit form, a second 7-bit address enabled by `dual_en_i`, and the general call address 0x00 enabled by `gc_en_i`.

When an address matches, the block pulls SDA low for the ninth SCL pulse. It then holds a match flag, the kind of address that matched and the received R/W bit until the next START or STOP. In 10-bit mode the first byte is a header, 11110 followed by the two top address bits and W. When the header matches, it is acknowledged and a second byte carrying the low eight address bits is received. After a complete 10-bit write match, a repeated START with the read form of the header is acknowledged directly. When no address matches, the block leaves the bus alone until the next START or STOP.

The controller is one state machine with six states. `ST_IDLE` is the bus-free state. `ST_ADDR` shifts address bits in. `ST_HOLD` holds the decision after the eighth bit. `ST_ACK` drives the acknowledge. `ST_MATCHED` holds the match. `ST_IGNORE` waits after a mismatch. Its transitions are:
- STOP goes from any state to `ST_IDLE`.
- START goes from any state to `ST_ADDR`.
- `ST_ADDR` goes to `ST_HOLD` on the eighth SCL rise.
- `ST_HOLD` goes to `ST_ACK` on the next SCL fall when an acknowledge is due, and to `ST_IGNORE` otherwise.
- `ST_ACK` goes, on the SCL fall that ends the ninth pulse, back to `ST_ADDR` for a 10-bit second byte, and to `ST_MATCHED` otherwise.

Top module: `i2c_addr_match`

## Requirements
- R1: Each bus line passes through a two-stage synchronizer and then a filter. A level change seen for fewer than FILT_CYC (default 3) consecutive system clocks is discarded, so a 2-clock SDA dip while SCL is high does not start address reception.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After reset and after every STOP, `sda_pull_o`, `match_o`, `match_kind_o` and `rw_o` are all 0.
- R3: Address bits are sampled on SCL rising edges, most significant first. Bit 0 of the first byte is the R/W bit (1 = read) and is reported on `rw_o` with the match.
- R4: With `ten_bit_i`=0, a first byte whose upper 7 bits equal `own_addr_i[6:0]` is acknowledged with kind 2'b01 (primary), for either R/W value. With `ten_bit_i`=1, the 7-bit primary compare is disabled.
- R5: With `dual_en_i`=1, upper 7 bits equal to `dual_addr_i` give an acknowledge with kind 2'b10. With `dual_en_i`=0 that address gets no acknowledge. The primary address has priority over the dual address.
- R6: With `gc_en_i`=1, the byte 0x00 (address 0, write) gives an acknowledge with kind 2'b11. Address 0 with R/W=1, or any address 0 while `gc_en_i`=0, gets no acknowledge. General call has the lowest priority.
- R7: On a match, `sda_pull_o` (1 = pull SDA low) rises at the SCL fall after the eighth bit and falls at the SCL fall that ends the ninth pulse.
- R8: With `ten_bit_i`=1, a first byte of 11110, then `own_addr_i[9:8]`, then 0 is acknowledged without raising `match_o`. A following byte equal to `own_addr_i[7:0]` is acknowledged and raises `match_o` with kind 2'b01 and `rw_o`=0.
- R9: In 10-bit mode, a header whose two address bits differ from `own_addr_i[9:8]` gets no acknowledge. A second byte that differs from `own_addr_i[7:0]` gets no acknowledge and leaves `match_o` at 0.
- R10: After a complete 10-bit write match, a repeated START followed by the header with R/W=1 is acknowledged at once and gives `match_o`=1, kind 2'b01, `rw_o`=1. After a STOP, that read header is no longer acknowledged.
- R11: After an address that gets no acknowledge, later bytes are not acknowledged, even one equal to the own address, until a START or STOP.
- R12: A repeated START clears `match_o` and restarts address reception. The new address is judged on its own.
- R13: `match_o`, `match_kind_o` and `rw_o` change at the SCL fall that starts the final acknowledge. They hold until the next START or STOP, and `match_o`=1 always comes with a nonzero kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL bus level |
| sda_i | input | 1 | Raw SDA bus level (wired bus, includes own pull) |
| ten_bit_i | input | 1 | 1 = primary address is 10-bit |
| own_addr_i | input | 10 | Primary own address (7-bit form uses bits 6:0) |
| dual_en_i | input | 1 | Enables the second 7-bit address |
| dual_addr_i | input | 7 | Second 7-bit own address |
| gc_en_i | input | 1 | Enables general call address 0x00 |
| sda_pull_o | output | 1 | 1 = drive SDA low (acknowledge) |
| match_o | output | 1 | Device addressed |
| match_kind_o | output | 2 | 01 primary, 10 dual, 11 general call, 00 none |
| rw_o | output | 1 | R/W bit of the matched first byte |

## Verification
A level change on a bus pin reaches the filtered line after SYNC_STAGES plus FILT_CYC clocks, which is 5 clocks with the defaults. The edge and condition detector adds no register stage. The state machine and the registered outputs update on the next edge, so `sda_pull_o` and the match outputs settle about 7 clocks after the bench moves SCL. The bench holds every bus phase for 10 clocks and samples at the end of a phase, on the falling clock edge. It reads the acknowledge in the middle of the ninth high phase, and reads the match outputs and the released pull one phase after the ninth SCL fall. Each sample therefore falls after the result is due and before the next stimulus.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR7_W  = 7;
    localparam int ADDR10_W = 10;

    // Upper five bits of the first byte that announces a 10-bit address
    localparam logic [4:0] TEN_HDR_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_ACK,
        ST_MATCHED,
        ST_IGNORE
    } am_state_e;

    typedef enum logic [1:0] {
        KIND_NONE    = 2'b00,
        KIND_PRIMARY = 2'b01,
        KIND_DUAL    = 2'b10,
        KIND_GCALL   = 2'b11
    } am_kind_e;

endpackage

// File: rtl/i2c_am_filter.sv
// Synchronizer followed by a persistence filter for one bus line (R1)
module i2c_am_filter #(
    parameter int   FILT_CYC    = 3,
    parameter int   SYNC_STAGES = 2,
    parameter logic RST_LVL     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);

    localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= {SYNC_STAGES{RST_LVL}};
            cnt_q   <= '0;
            clean_o <= RST_LVL;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            if (synced == clean_o) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_CYC - 1)) begin
                clean_o <= synced;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/i2c_am_cond.sv
// Bus condition and SCL edge detection on the filtered lines (R2)
module i2c_am_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;

endmodule

// File: rtl/i2c_am_decode.sv
// Address comparison for one received byte, with priority primary > dual > general call
module i2c_am_decode
    import i2c_am_pkg::*;
(
    input  logic [BYTE_W-1:0]   rx_byte_i,
    input  logic                second_i,
    input  logic                ten_bit_i,
    input  logic [ADDR10_W-1:0] own_addr_i,
    input  logic                dual_en_i,
    input  logic [ADDR7_W-1:0]  dual_addr_i,
    input  logic                gc_en_i,
    input  logic                ten_armed_i,
    output logic                ack_o,
    output logic                final_o,
    output logic                go_second_o,
    output am_kind_e            kind_o
);

    logic [ADDR7_W-1:0] addr7;
    logic [ADDR7_W-1:0] hdr7;
    logic               rw_bit;

    assign addr7  = rx_byte_i[BYTE_W-1:1];
    assign rw_bit = rx_byte_i[0];
    assign hdr7   = {TEN_HDR_PREFIX, own_addr_i[ADDR10_W-1:BYTE_W]};

    always_comb begin
        ack_o       = 1'b0;
        final_o     = 1'b0;
        go_second_o = 1'b0;
        kind_o      = KIND_NONE;
        if (second_i) begin
            if (rx_byte_i == own_addr_i[BYTE_W-1:0]) begin
                ack_o   = 1'b1;
                final_o = 1'b1;
                kind_o  = KIND_PRIMARY;
            end
        end else if (!ten_bit_i && addr7 == own_addr_i[ADDR7_W-1:0]) begin
            ack_o   = 1'b1;
            final_o = 1'b1;
            kind_o  = KIND_PRIMARY;
        end else if (ten_bit_i && addr7 == hdr7 && !rw_bit) begin
            ack_o       = 1'b1;
            go_second_o = 1'b1;
            kind_o      = KIND_PRIMARY;
        end else if (ten_bit_i && addr7 == hdr7 && rw_bit && ten_armed_i) begin
            ack_o   = 1'b1;
            final_o = 1'b1;
            kind_o  = KIND_PRIMARY;
        end else if (dual_en_i && addr7 == dual_addr_i) begin
            ack_o   = 1'b1;
            final_o = 1'b1;
            kind_o  = KIND_DUAL;
        end else if (gc_en_i && addr7 == '0 && !rw_bit) begin
            ack_o   = 1'b1;
            final_o = 1'b1;
            kind_o  = KIND_GCALL;
        end
    end

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int FILT_CYC    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic                ten_bit_i,
    input  logic [ADDR10_W-1:0] own_addr_i,
    input  logic                dual_en_i,
    input  logic [ADDR7_W-1:0]  dual_addr_i,
    input  logic                gc_en_i,
    output logic                sda_pull_o,
    output logic                match_o,
    output logic [1:0]          match_kind_o,
    output logic                rw_o
);

    localparam int NUM_LINES = 2;
    localparam int CNT_W     = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    // ---------------- input conditioning ----------------
    logic [NUM_LINES-1:0] raw_v;
    logic [NUM_LINES-1:0] filt_v;
    logic                 scl_f;
    logic                 sda_f;

    assign raw_v = {scl_i, sda_i};

    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
        i2c_am_filter #(
            .FILT_CYC   (FILT_CYC),
            .SYNC_STAGES(SYNC_STAGES),
            .RST_LVL    (1'b1)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_v[gi]),
            .clean_o(filt_v[gi])
        );
    end

    assign scl_f = filt_v[1];
    assign sda_f = filt_v[0];

    logic start_det;
    logic stop_det;
    logic scl_rise;
    logic scl_fall;

    i2c_am_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_f),
        .sda_i     (sda_f),
        .start_o   (start_det),
        .stop_o    (stop_det),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall)
    );

    // ---------------- receive datapath ----------------
    am_state_e          state_q, state_n;
    logic [CNT_W-1:0]   bit_cnt_q;
    logic [BYTE_W-2:0]  shift_q;
    logic [BYTE_W-1:0]  rx_byte;
    logic               second_q;
    logic               ten_armed_q;
    logic               ack_q, final_q, go2_q, rw_q;
    am_kind_e           kind_q;

    logic               dec_ack, dec_final, dec_go2;
    am_kind_e           dec_kind;
    logic               last_bit_rise;

    assign rx_byte       = {shift_q, sda_f};
    assign last_bit_rise = (state_q == ST_ADDR) && scl_rise && (bit_cnt_q == LAST_BIT);

    i2c_am_decode u_dec (
        .rx_byte_i  (rx_byte),
        .second_i   (second_q),
        .ten_bit_i  (ten_bit_i),
        .own_addr_i (own_addr_i),
        .dual_en_i  (dual_en_i),
        .dual_addr_i(dual_addr_i),
        .gc_en_i    (gc_en_i),
        .ten_armed_i(ten_armed_q),
        .ack_o      (dec_ack),
        .final_o    (dec_final),
        .go_second_o(dec_go2),
        .kind_o     (dec_kind)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        state_n = state_q;
        if (stop_det) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_n = ST_IDLE;
                ST_ADDR:    if (last_bit_rise) state_n = ST_HOLD;
                ST_HOLD:    if (scl_fall) state_n = ack_q ? ST_ACK : ST_IGNORE;
                ST_ACK:     if (scl_fall) state_n = go2_q ? ST_ADDR : ST_MATCHED;
                ST_MATCHED: state_n = ST_MATCHED;
                ST_IGNORE:  state_n = ST_IGNORE;
                default:    state_n = ST_IDLE;
            endcase
        end
    end

    // ---------------- state register and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            bit_cnt_q   <= '0;
            shift_q     <= '0;
            second_q    <= 1'b0;
            ten_armed_q <= 1'b0;
            ack_q       <= 1'b0;
            final_q     <= 1'b0;
            go2_q       <= 1'b0;
            rw_q        <= 1'b0;
            kind_q      <= KIND_NONE;
        end else begin
            state_q <= state_n;
            if (stop_det) begin
                bit_cnt_q   <= '0;
                second_q    <= 1'b0;
                ten_armed_q <= 1'b0;
            end else if (start_det) begin
                bit_cnt_q <= '0;
                second_q  <= 1'b0;
            end else begin
                if (state_q == ST_ADDR && scl_rise) begin
                    shift_q   <= rx_byte[BYTE_W-2:0];
                    bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                end
                if (last_bit_rise) begin
                    ack_q   <= dec_ack;
                    final_q <= dec_final;
                    go2_q   <= dec_go2;
                    kind_q  <= dec_kind;
                    if (!second_q) begin
                        rw_q <= sda_f;
                    end
                end
                if (state_q == ST_ACK && scl_fall) begin
                    if (go2_q) begin
                        second_q  <= 1'b1;
                        bit_cnt_q <= '0;
                    end
                    if (final_q && second_q) begin
                        ten_armed_q <= 1'b1;
                    end
                end
            end
        end
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull_o   <= 1'b0;
            match_o      <= 1'b0;
            match_kind_o <= KIND_NONE;
            rw_o         <= 1'b0;
        end else begin
            sda_pull_o <= (state_n == ST_ACK);
            if (start_det || stop_det) begin
                match_o      <= 1'b0;
                match_kind_o <= KIND_NONE;
                rw_o         <= 1'b0;
            end else if (state_q == ST_HOLD && state_n == ST_ACK && final_q) begin
                match_o      <= 1'b1;
                match_kind_o <= kind_q;
                rw_o         <= rw_q;
            end
        end
    end

endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_pull_o,
    input logic       match_o,
    input logic [1:0] kind_o,
    input logic       rw_o,
    input logic       dual_en,
    input logic       gc_en
);

    p_pull_rise_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_f)
        else $error("acknowledge started while SCL high");

    p_pull_fall_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull_o) |-> !scl_f)
        else $error("acknowledge released while SCL high");

    p_stop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!match_o && !sda_pull_o))
        else $error("STOP did not clear outputs");

    p_start_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !match_o)
        else $error("START did not clear match");

    p_kind_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (kind_o != 2'b00))
        else $error("match without kind");

    p_match_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && !start_det && !stop_det) |=> match_o)
        else $error("match dropped without bus condition");

    p_dual_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && kind_o == 2'b10) |-> dual_en)
        else $error("dual match while disabled");

    p_gcall_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && kind_o == 2'b11) |-> (gc_en && !rw_o))
        else $error("general call match invalid");

endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull_o(sda_pull_o),
    .match_o   (match_o),
    .kind_o    (match_kind_o),
    .rw_o      (rw_o),
    .dual_en   (dual_en_i),
    .gc_en     (gc_en_i)
);

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;      // system clocks per bus quarter-bit
    localparam int WATCHDOG   = 190000;
    localparam logic [6:0] OWN7  = 7'h3A;
    localparam logic [6:0] DUAL7 = 7'h55;
    localparam logic [9:0] OWN10 = 10'h2C7;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl_m, sda_m;
    logic       sda_line;
    logic       ten_bit, dual_en, gc_en;
    logic [9:0] own_addr;
    logic [6:0] dual_addr;
    logic       sda_pull, match, rw;
    logic [1:0] kind;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2c_addr_match u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .ten_bit_i   (ten_bit),
        .own_addr_i  (own_addr),
        .dual_en_i   (dual_en),
        .dual_addr_i (dual_addr),
        .gc_en_i     (gc_en),
        .sda_pull_o  (sda_pull),
        .match_o     (match),
        .match_kind_o(kind),
        .rw_o        (rw)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_bit(input logic b, output logic line_hi);
        sda_m = b;    wait_q();
        scl_m = 1'b1; wait_q();
        line_hi = sda_line;
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(b[i], s);
        send_bit(1'b1, s);
        acked = ~s;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic ack;
        scl_m = 1'b1; sda_m = 1'b1;
        ten_bit = 1'b0; own_addr = {3'b000, OWN7};
        dual_en = 1'b1; dual_addr = DUAL7; gc_en = 1'b1;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wait_q();
        chk("R2 reset pull", sda_pull, 0);
        chk("R2 reset match", match, 0);
        chk("R2 reset kind", kind, 0);
        chk("R2 reset rw", rw, 0);

        // Sweep every 7-bit address with both R/W values (R3, R4, R5, R6, R7, R13)
        for (int a = 0; a < 128; a++) begin
            for (int d = 0; d < 2; d++) begin
                int ek;
                if (a == OWN7)                     ek = 1;
                else if (a == DUAL7)               ek = 2;
                else if (a == 0 && d == 0)         ek = 3;
                else                               ek = 0;
                bus_start();
                send_byte({a[6:0], d[0]}, ack);
                chk("R4 R5 R6 sweep ack", ack, (ek != 0) ? 1 : 0);
                chk("R13 sweep match", match, (ek != 0) ? 1 : 0);
                chk("R13 sweep kind", kind, ek);
                chk("R3 sweep rw", rw, (ek != 0) ? d : 0);
                chk("R7 pull released", sda_pull, 0);
                bus_stop();
                chk("R2 stop clears", match, 0);
            end
        end

        // R5 / R6: enables off
        dual_en = 1'b0; gc_en = 1'b0;
        bus_start(); send_byte({DUAL7, 1'b0}, ack);
        chk("R5 dual disabled ack", ack, 0);
        chk("R5 dual disabled match", match, 0);
        bus_stop();
        bus_start(); send_byte(8'h00, ack);
        chk("R6 gcall disabled ack", ack, 0);
        bus_stop();

        // R11: after no-acknowledge, own address byte is ignored
        bus_start(); send_byte(8'h22, ack);
        chk("R11 nack first", ack, 0);
        send_byte({OWN7, 1'b0}, ack);
        chk("R11 ignored byte ack", ack, 0);
        chk("R11 ignored byte match", match, 0);
        bus_stop();

        // R12: repeated START restarts reception
        bus_start(); send_byte({OWN7, 1'b0}, ack);
        chk("R12 first ack", ack, 1);
        bus_start(); send_byte({7'h11, 1'b0}, ack);
        chk("R12 restart nack", ack, 0);
        chk("R12 restart match cleared", match, 0);
        bus_start(); send_byte({OWN7, 1'b1}, ack);
        chk("R12 restart ack", ack, 1);
        chk("R12 restart rw", rw, 1);
        bus_stop();

        // R1: 2-clock SDA dip while SCL high is not a START
        sda_m = 1'b0; repeat (2) @(negedge clk); sda_m = 1'b1;
        wait_q();
        scl_m = 1'b0; wait_q();
        send_byte({OWN7, 1'b0}, ack);
        chk("R1 glitch no start ack", ack, 0);
        chk("R1 glitch no match", match, 0);
        bus_stop();

        // 10-bit mode: own 0x2C7, header 0xF4 (write) / 0xF5 (read), low byte 0xC7
        ten_bit = 1'b1; own_addr = OWN10;
        bus_start(); send_byte(8'hF4, ack);
        chk("R8 header ack", ack, 1);
        chk("R8 header no match yet", match, 0);
        send_byte(8'hC7, ack);
        chk("R8 second ack", ack, 1);
        chk("R8 match", match, 1);
        chk("R8 kind", kind, 1);
        chk("R8 rw", rw, 0);
        bus_start(); send_byte(8'hF5, ack);
        chk("R10 read header ack", ack, 1);
        chk("R10 match", match, 1);
        chk("R10 rw", rw, 1);
        bus_stop();
        bus_start(); send_byte(8'hF5, ack);
        chk("R10 read header after stop", ack, 0);
        bus_stop();

        bus_start(); send_byte(8'hF4, ack);
        chk("R9 header ack", ack, 1);
        send_byte(8'hC6, ack);
        chk("R9 second mismatch ack", ack, 0);
        chk("R9 second mismatch match", match, 0);
        bus_stop();

        bus_start(); send_byte(8'hF6, ack);
        chk("R9 wrong header", ack, 0);
        bus_stop();

        bus_start(); send_byte({OWN10[6:0], 1'b0}, ack);
        chk("R4 7-bit compare off in 10-bit mode", ack, 0);
        bus_stop();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule